// File: doc/BRIEF.md
# Multicart Bank Control Register Block

This block sits on the CPU side of a cartridge that holds several games, each built for a different simple discrete mapper. It watches CPU writes and keeps the state that steers banking. Software reaches the registers indirectly. It first writes a select byte into a low address window, then writes data anywhere in the program-ROM window, and that data lands in the register the select byte names. Two registers belong to the running game: the character bank and the inner program bank. Two belong to the menu, or supervisor: the mode and the outer program bank.

The block drives two character-RAM bank lines directly. It also drives the nametable RAM A10 line, chosen by the mirroring field of the mode register. The stored inner bank, outer bank, program bank mode and outer size code are exported to a separate address translator. All state is in flops with a synchronous active-high reset. Each accepted write takes effect on the rising edge at which the write strobe is sampled high.

Top module: `cart_bank_regs`

## Requirements
- R1: After reset, chr_bank = 0, inner_bank = 0, outer_bank = 6'h3F, mirror_mode = 3, prg_mode = 3, outer_size = 3, and the nametable-select flag is 0. The select state after reset is supervisor group, index 1, so a program-window write made before any select write lands in the outer bank.
- R2: A write to any address from 0x5000 to 0x5FFF loads the select state. Data bit 7 picks the group (0 user, 1 supervisor) and data bit 0 picks the index. Bits 6..1 have no effect.
- R3: A write to 0x8000-0xFFFF with select user/index 0 stores data bits 1:0 into chr_bank.
- R4: A write to 0x8000-0xFFFF with select user/index 1 stores data bits 3:0 into inner_bank.
- R5: A write to 0x8000-0xFFFF with select supervisor/index 0 stores data bits 1:0 into mirror_mode, bits 3:2 into prg_mode and bits 5:4 into outer_size.
- R6: A write to 0x8000-0xFFFF with select supervisor/index 1 stores data bits 5:0 into outer_bank.
- R7: A write to either user register loads data bit 4 into the single nametable-select flag, but only while mirror_mode is 0 or 1. While mirror_mode is 2 or 3 the flag keeps its value, and the rest of that write is still stored.
- R8: nt_a10 follows the inputs without delay. It equals the nametable-select flag when mirror_mode is 0 or 1, ppu_a10 when it is 2, and ppu_a11 when it is 3.
- R9: A write below 0x5000 or within 0x6000-0x7FFF changes no state, and any cycle with cpu_we low changes no state.
- R10: A program-window write uses the select state that was in place before its own edge, so a select write followed by a program-window write on the next cycle targets the newly selected register. Program-window writes never alter the select state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, sampled on the rising edge |
| ppu_a10 | input | 1 | Picture-bus address bit 10 |
| ppu_a11 | input | 1 | Picture-bus address bit 11 |
| chr_bank | output | 2 | Character-RAM bank address lines |
| nt_a10 | output | 1 | Nametable RAM A10 |
| inner_bank | output | 4 | Stored inner program bank |
| outer_bank | output | 6 | Stored outer program bank |
| prg_mode | output | 2 | Program bank mode code |
| outer_size | output | 2 | Outer bank size code |
| mirror_mode | output | 2 | Mirroring mode code |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data, a 2-bit character bank, a 4-bit inner bank, a 6-bit outer bank and the nametable-select flag on data bit 4. At these widths every value of every field is reachable through random program-window writes. All four mirroring codes are reached, including the two pass-through modes in which bit-4 writes must be dropped. Random addresses cover both window edges and the two gaps that must be ignored.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  // Register target index: {group, index}
  typedef struct packed {
    logic sup;
    logic idx;
  } sel_t;

  localparam int unsigned TGT_CHR   = 0;
  localparam int unsigned TGT_INNER = 1;
  localparam int unsigned TGT_MODE  = 2;
  localparam int unsigned TGT_OUTER = 3;
  localparam int unsigned TGT_COUNT = 4;

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SEL_LO = 16'h5000,
  parameter logic [ADDR_W-1:0] SEL_HI = 16'h5FFF,
  parameter logic [ADDR_W-1:0] VAL_LO = 16'h8000
) (
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              sel_we,
  output logic              val_we
);

  logic in_sel_win;
  logic in_val_win;

  always_comb begin
    in_sel_win = (cpu_addr >= SEL_LO) && (cpu_addr <= SEL_HI);
    in_val_win = (cpu_addr >= VAL_LO);
    sel_we     = cpu_we && in_sel_win;
    val_we     = cpu_we && in_val_win;
  end

endmodule

// File: rtl/cbr_select.sv
module cbr_select
  import cart_bank_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned GROUP_BIT = 7,
  parameter int unsigned INDEX_BIT = 0,
  parameter sel_t        RST_SEL   = '{sup: 1'b1, idx: 1'b1}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic              val_we,
  input  logic [DATA_W-1:0] cpu_data,
  output sel_t              sel_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= RST_SEL;
    end else if (sel_we) begin
      sel_q.sup <= cpu_data[GROUP_BIT];
      sel_q.idx <= cpu_data[INDEX_BIT];
    end
  end

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    sel_we |=> (sel_q.sup == $past(cpu_data[GROUP_BIT])) && (sel_q.idx == $past(cpu_data[INDEX_BIT]))); // R2

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (val_we && !sel_we) |=> $stable(sel_q)); // R10

endmodule

// File: rtl/cbr_regfile.sv
module cbr_regfile
  import cart_bank_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CHR_W    = 2,
  parameter int unsigned INNER_W  = 4,
  parameter int unsigned OUTER_W  = 6,
  parameter int unsigned NT_BIT   = 4,
  parameter int unsigned MODE_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               val_we,
  input  sel_t               sel_q,
  input  logic [DATA_W-1:0]  cpu_data,
  output logic [CHR_W-1:0]   chr_q,
  output logic [INNER_W-1:0] inner_q,
  output logic [OUTER_W-1:0] outer_q,
  output logic [MODE_W-1:0]  mode_q,
  output logic               nt_flag_q
);

  localparam int unsigned TGT_W = $clog2(TGT_COUNT);

  logic [TGT_COUNT-1:0] tgt_we;
  logic [TGT_W-1:0]     tgt_idx;
  logic                 user_we;
  logic                 one_screen;
  logic                 unused_data_bits;

  assign tgt_idx = {sel_q.sup, sel_q.idx};

  for (genvar g = 0; g < TGT_COUNT; g++) begin : g_tgt_we
    assign tgt_we[g] = val_we && (tgt_idx == TGT_W'(g));
  end

  assign user_we    = tgt_we[TGT_CHR] | tgt_we[TGT_INNER];
  assign one_screen = (mode_q[1:0] == MIR_ONE_LO) || (mode_q[1:0] == MIR_ONE_HI);
  assign unused_data_bits = ^cpu_data[DATA_W-1:MODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_q <= '0;
    end else if (tgt_we[TGT_CHR]) begin
      chr_q <= cpu_data[CHR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inner_q <= '0;
    end else if (tgt_we[TGT_INNER]) begin
      inner_q <= cpu_data[INNER_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '1;
    end else if (tgt_we[TGT_MODE]) begin
      mode_q <= cpu_data[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outer_q <= '1;
    end else if (tgt_we[TGT_OUTER]) begin
      outer_q <= cpu_data[OUTER_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nt_flag_q <= 1'b0;
    end else if (user_we && one_screen) begin
      nt_flag_q <= cpu_data[NT_BIT];
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !val_we |=> $stable({chr_q, inner_q, outer_q, mode_q, nt_flag_q})); // R9

  AST_FLAG_GUARD: assert property (@(posedge clk) disable iff (rst)
    (user_we && mode_q[1]) |=> $stable(nt_flag_q)); // R7

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (chr_q == '0) && (inner_q == '0) && (&outer_q) && (&mode_q) && !nt_flag_q); // R1

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_we)); // R10

endmodule

// File: rtl/cbr_ntsel.sv
module cbr_ntsel
  import cart_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mirror,
  input  logic       nt_flag,
  input  logic       ppu_a10,
  input  logic       ppu_a11,
  output logic       nt_a10
);

  always_comb begin
    unique case (mirror_e'(mirror))
      MIR_VERT: nt_a10 = ppu_a10;
      MIR_HORZ: nt_a10 = ppu_a11;
      default:  nt_a10 = nt_flag;
    endcase
  end

  AST_NT_VERT: assert property (@(posedge clk) disable iff (rst)
    (mirror == MIR_VERT) |-> (nt_a10 == ppu_a10)); // R8

  AST_NT_HORZ: assert property (@(posedge clk) disable iff (rst)
    (mirror == MIR_HORZ) |-> (nt_a10 == ppu_a11)); // R8

endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CHR_W   = 2,
  parameter int unsigned INNER_W = 4,
  parameter int unsigned OUTER_W = 6,
  parameter int unsigned NT_BIT  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic               cpu_we,
  input  logic               ppu_a10,
  input  logic               ppu_a11,
  output logic [CHR_W-1:0]   chr_bank,
  output logic               nt_a10,
  output logic [INNER_W-1:0] inner_bank,
  output logic [OUTER_W-1:0] outer_bank,
  output logic [1:0]         prg_mode,
  output logic [1:0]         outer_size,
  output logic [1:0]         mirror_mode
);

  localparam int unsigned MODE_W = 6;

  logic       sel_we;
  logic       val_we;
  sel_t       sel_q;
  logic [MODE_W-1:0] mode_q;
  logic       nt_flag_q;

  cbr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .sel_we   (sel_we),
    .val_we   (val_we)
  );

  cbr_select #(.DATA_W(DATA_W)) u_select (
    .clk      (clk),
    .rst      (rst),
    .sel_we   (sel_we),
    .val_we   (val_we),
    .cpu_data (cpu_data),
    .sel_q    (sel_q)
  );

  cbr_regfile #(
    .DATA_W  (DATA_W),
    .CHR_W   (CHR_W),
    .INNER_W (INNER_W),
    .OUTER_W (OUTER_W),
    .NT_BIT  (NT_BIT),
    .MODE_W  (MODE_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .val_we    (val_we),
    .sel_q     (sel_q),
    .cpu_data  (cpu_data),
    .chr_q     (chr_bank),
    .inner_q   (inner_bank),
    .outer_q   (outer_bank),
    .mode_q    (mode_q),
    .nt_flag_q (nt_flag_q)
  );

  assign mirror_mode = mode_q[1:0];
  assign prg_mode    = mode_q[3:2];
  assign outer_size  = mode_q[5:4];

  cbr_ntsel u_nt (
    .clk     (clk),
    .rst     (rst),
    .mirror  (mirror_mode),
    .nt_flag (nt_flag_q),
    .ppu_a10 (ppu_a10),
    .ppu_a11 (ppu_a11),
    .nt_a10  (nt_a10)
  );

  AST_OUTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (val_we && sel_q.sup && sel_q.idx) |=> (outer_bank == $past(cpu_data[OUTER_W-1:0]))); // R6

  AST_CHR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (val_we && !sel_q.sup && !sel_q.idx) |=> (chr_bank == $past(cpu_data[CHR_W-1:0]))); // R3

endmodule

// File: tb/tb_cart_bank_regs.sv
module tb_cart_bank_regs;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_we = 1'b0;
  logic        ppu_a10 = 1'b0;
  logic        ppu_a11 = 1'b0;
  logic [1:0]  chr_bank;
  logic        nt_a10;
  logic [3:0]  inner_bank;
  logic [5:0]  outer_bank;
  logic [1:0]  prg_mode, outer_size, mirror_mode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model
  bit       m_sup, m_idx, m_flag;
  bit [1:0] m_chr;
  bit [3:0] m_inner;
  bit [5:0] m_outer, m_mode;

  cart_bank_regs dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_nt(bit a10, bit a11);
    case (m_mode[1:0])
      2'd2: return a10;
      2'd3: return a11;
      default: return m_flag;
    endcase
  endfunction

  function automatic string model_write(bit [15:0] a, bit [7:0] d);
    if (a >= 16'h5000 && a <= 16'h5FFF) begin
      m_sup = d[7]; m_idx = d[0];
      return "R2";
    end
    if (a < 16'h8000) return "R9";
    case ({m_sup, m_idx})
      2'b00: begin m_chr = d[1:0]; if (!m_mode[1]) m_flag = d[4]; return "R3/R7"; end
      2'b01: begin m_inner = d[3:0]; if (!m_mode[1]) m_flag = d[4]; return "R4/R7"; end
      2'b10: begin m_mode = d[5:0]; return "R5"; end
      default: begin m_outer = d[5:0]; return "R6"; end
    endcase
  endfunction

  task automatic check_all(string req);
    chk(req, chr_bank, m_chr);
    chk(req, inner_bank, m_inner);
    chk(req, outer_bank, m_outer);
    chk(req, {outer_size, prg_mode, mirror_mode}, m_mode);
    for (int k = 0; k < 4; k++) begin
      ppu_a10 = k[0]; ppu_a11 = k[1];
      #1;
      chk({req, " R8"}, nt_a10, exp_nt(k[0], k[1]));
    end
  endtask

  task automatic wr(bit [15:0] a, bit [7:0] d, bit we = 1);
    string req;
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = we;
    @(negedge clk);
    cpu_we = 1'b0;
    req = we ? model_write(a, d) : "R9";
    check_all(req);
  endtask

  // back-to-back: select then value on consecutive edges
  task automatic wr_pair(bit [7:0] s, bit [15:0] a, bit [7:0] d);
    string req;
    @(negedge clk);
    cpu_addr = 16'h5ABC; cpu_data = s; cpu_we = 1'b1;
    @(negedge clk);
    void'(model_write(16'h5ABC, s));
    cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_we = 1'b0;
    req = model_write(a, d);
    check_all({req, " R10"});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [15:0] a;
    bit [7:0]  d;
    int unsigned seed;
    seed = 32'd20240607;
    void'($urandom(seed));
    m_sup = 1; m_idx = 1; m_flag = 0; m_chr = 0; m_inner = 0;
    m_outer = 6'h3F; m_mode = 6'h3F;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");
    // R1: default select targets outer bank
    wr(16'hFFFF, 8'h15);
    chk("R1", outer_bank, 6'h15);
    // R2: bits 6..1 ignored -> supervisor index 0 (mode)
    wr(16'h5000, 8'hFE);
    wr(16'h8000, 8'h24);
    chk("R5", mirror_mode, 0);
    // R7 one-screen flag via chr reg
    wr(16'h5FFF, 8'h00);
    wr(16'hC000, 8'h13);
    chk("R7", nt_a10, 1);
    // switch to vertical, flag write must be dropped
    wr(16'h5000, 8'h80);
    wr(16'h8000, 8'h02);
    wr(16'h5000, 8'h01);
    wr(16'h9000, 8'h0A);  // bit4 = 0, dropped
    chk("R4", inner_bank, 4'hA);
    wr(16'h5000, 8'h80);
    wr(16'h8000, 8'h01);
    chk("R7", nt_a10, 1);
    // R9 ignored windows and we low
    wr(16'h4FFF, 8'h00);
    wr(16'h6000, 8'h00);
    wr(16'h7FFF, 8'hFF);
    wr(16'h8000, 8'h3C, 1'b0);
    wr(16'h5000, 8'h00, 1'b0);
    // R10: back-to-back select/value and repeated value writes
    wr_pair(8'h81, 16'hA000, 8'h2B);
    wr_pair(8'h01, 16'hE000, 8'h07);
    wr(16'hE001, 8'h05);
    chk("R10", inner_bank, 5);
    // random mix
    for (int i = 0; i < 800; i++) begin
      int kind;
      kind = $urandom_range(0, 9);
      d = 8'($urandom);
      case (kind)
        0, 1, 2: a = 16'h5000 | 16'($urandom_range(0, 16'h0FFF));
        3, 4, 5, 6: a = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
        7: a = 16'($urandom_range(0, 16'h4FFF));
        8: a = 16'h6000 | 16'($urandom_range(0, 16'h1FFF));
        default: a = 16'($urandom);
      endcase
      if (kind == 9 && $urandom_range(0, 1) == 1) wr(a, d, 1'b0);
      else if (kind == 2) wr_pair(d, 16'h8000 | 16'($urandom_range(0, 16'h7FFF)), 8'($urandom));
      else wr(a, d);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule